// File: doc/BRIEF.md
# MDIO Management Controller with Background PHY Scan

This block is a register-mapped master for the two-wire management bus that sits between a MAC and its PHYs. It makes the management clock from the system clock through a programmable divider. It sends clause-22 read and write frames on a data pin that it can release, so the PHY can answer on the same wire. Software starts one access at a time through an access register. It then polls a start flag in that register until the flag clears by itself, and reads back the acknowledge bit and the returned data.

When software has no access waiting and scanning is enabled, a scan engine uses the free bus time. It reads the status register of every PHY address in turn. For each address it records whether the PHY answered, and it records the link bit that PHY reported. A software access always goes ahead of the next scan frame. Once scanning is disabled and all pending work has finished, an idle flag is raised.

Top module: `mdio_ctrl`

## Requirements
- R1: The divider field is bits 15:0 of the control word (word address 0). MDC has a period of max(divider,1)+1 system clock cycles, so a divider of 0 behaves like a divider of 1.
- R2: Word addresses are 0 control, 1 access, 2 alive, 3 link. The read data shows the selected word one clock after the address is applied. After reset, control reads 0x8000FFFF and the other three words read 0.
- R3: Every frame is sent MSB first in this order: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, 2 turnaround bits, 16 data bits. The data output changes only on a falling MDC edge.
- R4: During a read, the driver is released for both turnaround bits and all 16 data bits. ACK (access bit 29) is 1 exactly when the PHY drove the second turnaround bit low. The 16 data bits are then returned in access bits 15:0.
- R5: During a write, the turnaround is driven as 10 and access bits 15:0 are sent as data. After the write completes, ACK reads 0 and the data field still holds the value that was written.
- R6: The access word has GO at bit 31, WRITE at bit 30 (0 means read), ACK at bit 29, bits 28:26 reading 0, the register address in bits 25:21 and the PHY address in bits 20:16. Writing the word with GO set starts a frame. GO reads 1 until that frame completes and then clears by itself.
- R7: A write to the access word while GO is 1 has no effect on the word or on the bus.
- R8: While enable (control bit 30) is 1 and no access is pending, the scan engine reads register 1 of PHY addresses 0, 1, and so on up to 31, then starts again at 0.
- R9: After each scan read, the alive bit (word 2) for that address is set if the PHY acknowledged and cleared if it did not.
- R10: After each scan read, the link bit (word 3) for that address takes bit 2 of the returned status if the PHY acknowledged, and 0 if it did not.
- R11: A software access requested while a scan frame is in flight goes out as the very next frame, ahead of any further scan frame.
- R12: Clearing enable lets the frame in flight finish and then stops scanning. Control bit 31 (idle) reads 1 only when enable is 0, GO is 0 and no frame is running. Setting enable again restarts the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data output value |
| mdio_oe | output | 1 | Data output enable (1 drives the pin) |
| mdio_i | input | 1 | Data pin as seen on the wire |

## Verification
The hardest case to reach from the ports is a software access that lands while a scan frame is partway through. The bench's PHY model counts each frame header once it has been fully decoded. The stimulus waits for that count to step and then writes the access word at once, so the request arrives in the middle of a scan frame. The frame log must then show the software frame next, followed by the scan frame for the following address. A PHY is also taken off the bus while scanning runs, so that alive and link bits are seen clearing as well as setting.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 4 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int NPHY       = 1 << PHY_AW;

  typedef struct packed {
    logic              wr;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
    logic [DATA_W-1:0] data;
  } mdio_req_t;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_ACCESS = 2'd1,
    RA_ALIVE  = 2'd2,
    RA_LINK   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             tick_fall,
  output logic             tick_rise
);
  logic [DIV_W-1:0] cnt, lim, half;
  logic [DIV_W:0]   lim_p1;

  always_comb begin
    lim    = (div == '0) ? DIV_W'(1) : div;
    lim_p1 = {1'b0, lim} + 1'b1;
    half   = lim_p1[DIV_W:1];
  end

  assign tick_fall = (cnt == '0);
  assign tick_rise = (cnt == half);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b1;
    end else begin
      cnt <= (cnt >= lim) ? '0 : cnt + 1'b1;
      if (tick_fall)      mdc <= 1'b0;
      else if (tick_rise) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_fall,
  input  logic              tick_rise,
  input  logic              start,
  input  mdio_req_t         req,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int IDX_W   = $clog2(FRAME_BITS);
  localparam int TA_POS  = FRAME_BITS - DATA_W - 2;
  localparam int ACK_POS = TA_POS + 1;
  localparam int DAT_POS = TA_POS + 2;

  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      idx;
  logic                  armed, is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ack     <= 1'b0;
      rdata   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      sh      <= '0;
      idx     <= '0;
      armed   <= 1'b0;
      is_rd   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          armed <= 1'b0;
          idx   <= '0;
          is_rd <= !req.wr;
          ack   <= 1'b0;
          sh    <= {{PRE_BITS{1'b1}}, 2'b01, (req.wr ? 2'b01 : 2'b10), req.phy, req.regad,
                    (req.wr ? 2'b10 : 2'b11), (req.wr ? req.data : {DATA_W{1'b1}})};
        end
      end else if (tick_fall) begin
        mdio_o  <= sh[FRAME_BITS-1];
        mdio_oe <= !(is_rd && idx >= IDX_W'(TA_POS));
        armed   <= 1'b1;
      end else if (tick_rise && armed) begin
        if (is_rd && idx == IDX_W'(ACK_POS)) ack <= !mdio_i;
        if (is_rd && idx >= IDX_W'(DAT_POS)) rdata <= {rdata[DATA_W-2:0], mdio_i};
        sh <= sh << 1;
        if (idx == IDX_W'(FRAME_BITS - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          mdio_oe <= 1'b0;
          armed   <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int             DIV_W    = 16,
  parameter logic [DIV_W-1:0] DIV_RST = '1,
  parameter int             SCAN_REG = 1,
  parameter int             LINK_BIT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic              en_q, go_q, ack_q, idle_q;
  logic              srv_user, srv_scan;
  mdio_req_t         user_req, scan_req, eng_req;
  logic [NPHY-1:0]   alive_q, link_q;
  logic [PHY_AW-1:0] scan_ptr;
  logic              tick_fall, tick_rise, start;
  logic              eng_busy, eng_done, eng_ack;
  logic [DATA_W-1:0] eng_rdata;
  logic              wdata_unused;

  assign wdata_unused = ^reg_wdata[29:26];

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .div(div_q), .mdc(mdc),
    .tick_fall(tick_fall), .tick_rise(tick_rise)
  );

  always_comb begin
    scan_req = '{wr: 1'b0, phy: scan_ptr, regad: REG_AW'(SCAN_REG), data: '0};
    eng_req  = go_q ? user_req : scan_req;
    start    = !eng_busy && !srv_user && !srv_scan && (go_q || en_q);
  end

  mdio_frame u_frame (
    .clk(clk), .rst(rst), .tick_fall(tick_fall), .tick_rise(tick_rise),
    .start(start), .req(eng_req), .mdio_i(mdio_i),
    .busy(eng_busy), .done(eng_done), .ack(eng_ack), .rdata(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= DIV_RST;
      en_q      <= 1'b0;
      go_q      <= 1'b0;
      ack_q     <= 1'b0;
      user_req  <= '0;
      alive_q   <= '0;
      link_q    <= '0;
      scan_ptr  <= '0;
      srv_user  <= 1'b0;
      srv_scan  <= 1'b0;
      idle_q    <= 1'b1;
      reg_rdata <= '0;
    end else begin
      if (start) begin
        srv_user <= go_q;
        srv_scan <= !go_q;
      end
      if (eng_done && srv_user) begin
        go_q     <= 1'b0;
        srv_user <= 1'b0;
        ack_q    <= eng_ack;
        if (!user_req.wr) user_req.data <= eng_rdata;
      end
      if (eng_done && srv_scan) begin
        srv_scan          <= 1'b0;
        alive_q[scan_ptr] <= eng_ack;
        link_q[scan_ptr]  <= eng_ack & eng_rdata[LINK_BIT];
        scan_ptr          <= scan_ptr + 1'b1;
      end
      if (reg_wr) begin
        case (reg_addr_e'(reg_addr))
          RA_CTRL: begin
            div_q <= reg_wdata[DIV_W-1:0];
            en_q  <= reg_wdata[30];
          end
          RA_ACCESS: if (!go_q) begin
            go_q     <= reg_wdata[31];
            ack_q    <= 1'b0;
            user_req <= '{wr: reg_wdata[30], phy: reg_wdata[20:16],
                          regad: reg_wdata[25:21], data: reg_wdata[15:0]};
          end
          default: ;
        endcase
      end
      idle_q <= !en_q && !go_q && !eng_busy && !srv_user && !srv_scan;
      case (reg_addr_e'(reg_addr))
        RA_CTRL:   reg_rdata <= {idle_q, en_q, {(30-DIV_W){1'b0}}, div_q};
        RA_ACCESS: reg_rdata <= {go_q, user_req.wr, ack_q, 3'b000,
                                 user_req.regad, user_req.phy, user_req.data};
        RA_ALIVE:  reg_rdata <= alive_q;
        default:   reg_rdata <= link_q;
      endcase
    end
  end
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic idle_q,
  input logic go_q,
  input logic en_q,
  input logic eng_done,
  input logic srv_user,
  input logic srv_scan
);
  // R3: output data moves only with a falling MDC
  p_data_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));
  // R4: the driver turns on only at a falling MDC
  p_drive_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> $fell(mdc));
  // R6: GO clears only after a frame has completed
  p_go_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(go_q) |-> $past(eng_done));
  // R8: a scan frame starts only when enabled and no access is pending
  p_scan_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(srv_scan) |-> ($past(en_q) && !$past(go_q)));
  // R11: the bus serves one owner at a time
  p_one_owner_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({srv_user, srv_scan}));
  // R12: while idle the pin is released
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> !mdio_oe);
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .idle_q(idle_q), .go_q(go_q), .en_q(en_q), .eng_done(eng_done),
  .srv_user(srv_user), .srv_scan(srv_scan)
);

// File: tb/mdio_ctrl_test.sv
module mdio_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv_en = 1'b0;
  logic        phy_drv_val = 1'b1;
  logic        bus_line;

  assign bus_line = mdio_oe ? mdio_o : (phy_drv_en ? phy_drv_val : 1'b1);
  assign mdio_i   = bus_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int errors = 0;
  int checks = 0;
  int started = 0;
  logic [31:0] present;
  logic [15:0] mem [0:31][0:31];
  int q_phy[$];
  int q_reg[$];
  int q_wr[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] acc(input logic go, input logic w, input logic a,
                                      input int rg, input int ph, input logic [15:0] d);
    acc = {go, w, a, 3'b000, 5'(rg), 5'(ph), d};
  endfunction

  // R4: the controller must have released the pin whenever the PHY drives it
  always @(negedge clk) if (phy_drv_en) check("R4 released while PHY drives", {31'b0, mdio_oe}, 32'd0);

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_go();
    logic [31:0] v;
    v = 32'hFFFF_FFFF;
    while (v[31]) rd(2'd1, v);
  endtask

  task automatic wait_frames(input int k);
    int tgt;
    tgt = started + k;
    while (started < tgt) @(posedge clk);
  endtask

  task automatic period(input string tag, input int exp);
    time t0;
    @(posedge mdc); @(posedge mdc);
    t0 = $time;
    @(posedge mdc);
    check(tag, 32'(($time - t0) / CLK_PERIOD), 32'(exp));
  endtask

  // Behavioural PHY: decodes frames, answers reads, stores writes, logs headers
  initial begin
    int ones;
    logic [12:0] hdr;
    logic [17:0] wb;
    logic [4:0]  ph, rg;
    logic [15:0] d;
    forever begin
      ones = 0;
      forever begin
        @(posedge mdc);
        if (bus_line) ones++;
        else if (ones >= 32) break;
        else ones = 0;
      end
      for (int i = 0; i < 13; i++) begin
        @(posedge mdc); hdr = {hdr[11:0], bus_line};
      end
      ph = hdr[9:5];
      rg = hdr[4:0];
      check("R3 second start bit", {31'b0, hdr[12]}, 32'd1);
      q_phy.push_back(int'(ph));
      q_reg.push_back(int'(rg));
      q_wr.push_back(hdr[11:10] == 2'b01 ? 1 : 0);
      started++;
      if (hdr[11:10] == 2'b10) begin
        if (present[ph]) begin
          d = mem[ph][rg];
          @(negedge mdc);
          @(negedge mdc); phy_drv_en = 1'b1; phy_drv_val = 1'b0;
          for (int i = 15; i >= 0; i--) begin
            @(negedge mdc); phy_drv_val = d[i];
          end
          @(negedge mdc); phy_drv_en = 1'b0;
        end else begin
          repeat (18) @(posedge mdc);
        end
      end else if (hdr[11:10] == 2'b01) begin
        for (int i = 0; i < 18; i++) begin
          @(posedge mdc); wb = {wb[16:0], bus_line};
        end
        check("R5 write turnaround 10", {30'b0, wb[17:16]}, 32'd2);
        if (present[ph]) mem[ph][rg] = wb[15:0];
      end else begin
        check("R3 opcode", {30'b0, hdr[11:10]}, 32'd2);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R12 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, s0, bad;
    present = 32'h8000_0021;
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++)
        mem[p][r] = 16'h1000 | 16'(p << 5) | 16'(r);
    mem[0][1]  = 16'h7809;
    mem[5][1]  = 16'h780D;
    mem[31][1] = 16'h782D;

    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    rd(2'd0, v); check("R2 control after reset", v, 32'h8000_FFFF);
    rd(2'd1, v); check("R2 access after reset", v, 32'h0);
    rd(2'd2, v); check("R2 alive after reset", v, 32'h0);
    rd(2'd3, v); check("R2 link after reset", v, 32'h0);

    wr(2'd0, 32'h3);        period("R1 period divider 3", 4);
    wr(2'd0, 32'h0);        period("R1 period divider 0 clamped", 2);
    wr(2'd0, 32'h1);        period("R1 period divider 1", 2);

    wr(2'd1, acc(1, 0, 0, 3, 5, 16'h0));
    rd(2'd1, v); check("R6 GO reads 1 while busy", {31'b0, v[31]}, 32'd1);
    wait_go();
    rd(2'd1, v); check("R4 read present PHY", v, acc(0, 0, 1, 3, 5, mem[5][3]));

    wr(2'd1, acc(1, 0, 0, 4, 9, 16'h0));
    wait_go();
    rd(2'd1, v); check("R4 absent PHY gives no ACK", {31'b0, v[29]}, 32'd0);

    n = started;
    wr(2'd1, acc(1, 0, 0, 2, 0, 16'h0));
    wr(2'd1, acc(1, 1, 0, 7, 31, 16'h1234));
    wait_go();
    rd(2'd1, v); check("R7 second write ignored, word", v, acc(0, 0, 1, 2, 0, mem[0][2]));
    check("R7 second write ignored, frames", 32'(started - n), 32'd1);

    wr(2'd1, acc(1, 1, 0, 7, 31, 16'hBEEF));
    wait_go();
    rd(2'd1, v); check("R5 write completes with ACK 0", v, acc(0, 1, 0, 7, 31, 16'hBEEF));
    check("R5 PHY received data", {16'b0, mem[31][7]}, 32'h0000_BEEF);
    wr(2'd1, acc(1, 0, 0, 7, 31, 16'h0));
    wait_go();
    rd(2'd1, v); check("R4 read back written value", v, acc(0, 0, 1, 7, 31, 16'hBEEF));

    s0 = started;
    wr(2'd0, 32'h4000_0001);
    wait_frames(34);
    rd(2'd0, v); check("R12 not idle while scanning", v, 32'h4000_0001);
    check("R8 scan starts at address 0", 32'(q_phy[s0]), 32'd0);
    bad = 0;
    for (int i = s0; i < s0 + 34; i++) begin
      if (q_reg[i] != 1 || q_wr[i] != 0) bad++;
      if (i > s0 && q_phy[i] != ((q_phy[i-1] + 1) % 32)) bad++;
    end
    check("R8 scan order and wrap", 32'(bad), 32'd0);
    rd(2'd2, v); check("R9 alive map", v, 32'h8000_0021);
    rd(2'd3, v); check("R10 link map", v, 32'h8000_0020);

    n = started;
    while (started == n) @(posedge clk);
    wr(2'd1, acc(1, 0, 0, 3, 5, 16'h0));
    wait_go();
    wait_frames(2);
    check("R11 access is next frame, PHY", 32'(q_phy[n+1]), 32'd5);
    check("R11 access is next frame, register", 32'(q_reg[n+1]), 32'd3);
    check("R11 scan resumes after access", 32'(q_phy[n+2]), 32'((q_phy[n] + 1) % 32));
    rd(2'd1, v); check("R11 access data", v, acc(0, 0, 1, 3, 5, mem[5][3]));

    present[5] = 1'b0;
    wait_frames(33);
    rd(2'd2, v); check("R9 alive bit clears", v, 32'h8000_0001);
    rd(2'd3, v); check("R10 link bit clears", v, 32'h8000_0000);

    wr(2'd0, 32'h1);
    repeat (300) @(posedge clk);
    rd(2'd0, v); check("R12 idle after disable", v, 32'h8000_0001);
    n = started;
    repeat (400) @(posedge clk);
    check("R12 no frames while disabled", 32'(started), 32'(n));
    wr(2'd0, 32'h4000_0001);
    repeat (300) @(posedge clk);
    check("R12 scan restarts", {31'b0, started > n}, 32'd1);
    rd(2'd0, v); check("R12 idle clears on enable", v, 32'h4000_0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule